// File: doc/BRIEF.md
# Stream-to-Memory Transfer Status Tracker

This block sits on the write side of a DMA engine that moves a packet stream into memory. For each transfer it takes a descriptor start pulse, which carries the programmed length and the interrupt masks for that transfer. It then watches the stream beats that the write path accepts. It counts payload bytes from the start-of-packet beat onward and ORs each beat's error flags into a running set. The transfer ends on the end-of-packet beat, or earlier when the byte count passes the programmed length.

When the transfer ends, the block forms a 256-bit status word and presents it on a valid/ready source port. A downstream interrupt unit uses the word: it carries the byte count, the accumulated errors, the early-end flag, the three mask fields copied from the descriptor and a snapshot of a buffer-full level. The block takes no new descriptor until that word has been handed off.

Top module: `wr_xfer_status_tracker`

## Requirements
- R1: After reset `stat_valid` is low, and it stays low while no transfer has been started.
- R2: Status bits 31:0 hold the sum of `beat_bytes` over the accepted beats from the start-of-packet beat through the ending beat. Beats seen before the first start-of-packet beat after a descriptor start are ignored, including their error flags and their end-of-packet flag.
- R3: Status bits 39:32 hold the OR of `beat_err` over every counted beat of the transfer.
- R4: If the running count goes above `desc_len` on a beat that is not end-of-packet, the transfer ends on that beat. Status bit 40 is then 1, and the count includes the bytes of that beat.
- R5: An end-of-packet beat ends the transfer with bit 40 at 0, even when the count on that beat goes above `desc_len`. A count equal to `desc_len` without end-of-packet does not end the transfer.
- R6: Bit 41 is `desc_done_irq_mask`, bits 49:42 are `desc_err_irq_mask` and bit 50 is `desc_early_irq_mask`, all as given with the accepted descriptor start. Bits 255:52 are zero.
- R7: Bit 51 is the value of `buf_full` in the cycle of the ending beat.
- R8: `stat_valid` rises in the cycle after the ending beat. From then on, `stat_valid` and `stat_data` stay unchanged until a cycle in which `stat_ready` is high. That handshake drops `stat_valid`.
- R9: A descriptor start while a status word is pending has no effect. After the handshake, no transfer is armed.
- R10: A descriptor start clears the count and the error set, even in the middle of a transfer. A beat in the same cycle as an accepted start is not counted.
- R11: Beats that arrive when no descriptor is armed are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_start | input | 1 | Descriptor start pulse |
| desc_len | input | 32 | Programmed transfer length in bytes |
| desc_done_irq_mask | input | 1 | Completion interrupt mask for the status word |
| desc_err_irq_mask | input | 8 | Per-error interrupt mask for the status word |
| desc_early_irq_mask | input | 1 | Early-end interrupt mask for the status word |
| beat_valid | input | 1 | A stream beat was accepted this cycle |
| beat_sop | input | 1 | Beat is start of packet |
| beat_eop | input | 1 | Beat is end of packet |
| beat_bytes | input | 4 | Number of valid bytes in the beat (0 to 8) |
| beat_err | input | 8 | Error flags carried by the beat |
| buf_full | input | 1 | Buffer-full level sampled into the status word |
| stat_valid | output | 1 | Status word valid |
| stat_data | output | 256 | Status word |
| stat_ready | input | 1 | Consumer accepts the status word |

## Verification
The assertions assume three things about the inputs. `beat_bytes` never exceeds the beat width. `desc_len` stays below the top of the 32-bit range, so the count does not saturate. The consumer may hold `stat_ready` low for any number of cycles. The stimulus keeps to these limits: byte counts are taken modulo the beat width plus one, lengths are small, and `stat_ready` is held low for two cycles before each handshake. During that wait the bench also issues a descriptor start, which must be ignored.

// File: rtl/xfer_status_pkg.sv
package xfer_status_pkg;
  localparam int STAT_W        = 256;
  localparam int BYTES_LSB     = 0;
  localparam int ERR_LSB       = 32;
  localparam int EARLY_BIT     = 40;
  localparam int DONE_MSK_BIT  = 41;
  localparam int ERR_MSK_LSB   = 42;
  localparam int EARLY_MSK_BIT = 50;
  localparam int BUF_FULL_BIT  = 51;
  localparam int USED_W        = 52;

  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_RUN   = 2'd2,
    TRK_HOLD  = 2'd3
  } trk_state_e;

  typedef struct packed {
    logic       done_msk;
    logic [7:0] err_msk;
    logic       early_msk;
  } irq_masks_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       desc_start,
  input  logic       beat_valid,
  input  logic       beat_sop,
  input  logic       beat_eop,
  input  logic       over_len,
  input  logic       stat_ready,
  output logic       accept,
  output logic       count_en,
  output logic       finish,
  output logic       early_hit,
  output logic       pending
);
  trk_state_e state_q, state_d;

  always_comb begin
    accept    = desc_start && (state_q != TRK_HOLD);
    count_en  = beat_valid && !accept &&
                ((state_q == TRK_ARMED && beat_sop) || state_q == TRK_RUN);
    finish    = count_en && (beat_eop || over_len);
    early_hit = count_en && over_len && !beat_eop;
  end

  always_comb begin
    state_d = state_q;
    if (accept)
      state_d = TRK_ARMED;
    else if (finish)
      state_d = TRK_HOLD;
    else if (state_q == TRK_ARMED && count_en)
      state_d = TRK_RUN;
    else if (state_q == TRK_HOLD && stat_ready)
      state_d = TRK_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= TRK_IDLE;
    else     state_q <= state_d;
  end

  assign pending = (state_q == TRK_HOLD);

  // R9
  start_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && desc_start && !stat_ready) |=> pending);

  // R11
  idle_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_IDLE) |-> !count_en);
endmodule

// File: rtl/xfer_accum.sv
module xfer_accum #(
  parameter int LEN_W    = 32,
  parameter int ERR_W    = 8,
  parameter int CNT_IN_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                count_en,
  input  logic [CNT_IN_W-1:0] beat_bytes,
  input  logic [ERR_W-1:0]    beat_err,
  input  logic [LEN_W-1:0]    len_q,
  output logic [LEN_W-1:0]    sum_bytes,
  output logic [ERR_W-1:0]    sum_err,
  output logic                over_len
);
  localparam int WIDE_W = LEN_W + 1;

  logic [LEN_W-1:0]  cnt_q;
  logic [ERR_W-1:0]  err_q;
  logic [WIDE_W-1:0] cnt_wide;

  always_comb begin
    cnt_wide  = {1'b0, cnt_q} + {{(WIDE_W-CNT_IN_W){1'b0}}, beat_bytes};
    over_len  = cnt_wide > {1'b0, len_q};
    sum_bytes = cnt_wide[LEN_W] ? {LEN_W{1'b1}} : cnt_wide[LEN_W-1:0];
    sum_err   = err_q | beat_err;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (count_en) cnt_q <= sum_bytes;
  end

  for (genvar g = 0; g < ERR_W; g++) begin : g_err_bit
    always_ff @(posedge clk) begin
      if (rst || clear)                  err_q[g] <= 1'b0;
      else if (count_en && beat_err[g])  err_q[g] <= 1'b1;
    end
  end

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R2
  cnt_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (count_en && !clear) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/status_pack.sv
module status_pack
  import xfer_status_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              finish,
  input  logic              early_hit,
  input  logic [LEN_W-1:0]  sum_bytes,
  input  logic [ERR_W-1:0]  sum_err,
  input  irq_masks_t        masks,
  input  logic              buf_full,
  output logic [STAT_W-1:0] stat_data
);
  logic [USED_W-1:0] word_q;
  logic [USED_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[BYTES_LSB +: LEN_W]   = sum_bytes;
    word_d[ERR_LSB +: ERR_W]     = sum_err;
    word_d[EARLY_BIT]            = early_hit;
    word_d[DONE_MSK_BIT]         = masks.done_msk;
    word_d[ERR_MSK_LSB +: 8]     = masks.err_msk;
    word_d[EARLY_MSK_BIT]        = masks.early_msk;
    word_d[BUF_FULL_BIT]         = buf_full;
  end

  always_ff @(posedge clk) begin
    if (rst)         word_q <= '0;
    else if (finish) word_q <= word_d;
  end

  assign stat_data = {{(STAT_W-USED_W){1'b0}}, word_q};
endmodule

// File: rtl/wr_xfer_status_tracker.sv
module wr_xfer_status_tracker
  import xfer_status_pkg::*;
#(
  parameter int LEN_W      = 32,
  parameter int ERR_W      = 8,
  parameter int BEAT_BYTES = 8,
  localparam int CNT_IN_W  = $clog2(BEAT_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                desc_start,
  input  logic [LEN_W-1:0]    desc_len,
  input  logic                desc_done_irq_mask,
  input  logic [7:0]          desc_err_irq_mask,
  input  logic                desc_early_irq_mask,
  input  logic                beat_valid,
  input  logic                beat_sop,
  input  logic                beat_eop,
  input  logic [CNT_IN_W-1:0] beat_bytes,
  input  logic [ERR_W-1:0]    beat_err,
  input  logic                buf_full,
  output logic                stat_valid,
  output logic [STAT_W-1:0]   stat_data,
  input  logic                stat_ready
);
  logic             accept, count_en, finish, early_hit, over_len;
  logic [LEN_W-1:0] len_q, sum_bytes;
  logic [ERR_W-1:0] sum_err;
  irq_masks_t       masks_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      masks_q <= '0;
    end else if (accept) begin
      len_q   <= desc_len;
      masks_q <= '{done_msk: desc_done_irq_mask,
                   err_msk: desc_err_irq_mask,
                   early_msk: desc_early_irq_mask};
    end
  end

  xfer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .desc_start(desc_start),
    .beat_valid(beat_valid), .beat_sop(beat_sop), .beat_eop(beat_eop),
    .over_len(over_len), .stat_ready(stat_ready),
    .accept(accept), .count_en(count_en), .finish(finish),
    .early_hit(early_hit), .pending(stat_valid)
  );

  xfer_accum #(.LEN_W(LEN_W), .ERR_W(ERR_W), .CNT_IN_W(CNT_IN_W)) u_accum (
    .clk(clk), .rst(rst), .clear(accept), .count_en(count_en),
    .beat_bytes(beat_bytes), .beat_err(beat_err), .len_q(len_q),
    .sum_bytes(sum_bytes), .sum_err(sum_err), .over_len(over_len)
  );

  status_pack #(.LEN_W(LEN_W), .ERR_W(ERR_W)) u_pack (
    .clk(clk), .rst(rst), .finish(finish), .early_hit(early_hit),
    .sum_bytes(sum_bytes), .sum_err(sum_err), .masks(masks_q),
    .buf_full(buf_full), .stat_data(stat_data)
  );

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_ready) |=> (stat_valid && $stable(stat_data)));

  // R4
  early_count_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_data[EARLY_BIT]) |-> (stat_data[BYTES_LSB +: LEN_W] > len_q));

  // R8
  beat_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> !finish);
endmodule

// File: tb/wr_xfer_status_tracker_test.sv
`timescale 1ns/1ps
module wr_xfer_status_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic desc_start = 0, done_m = 0, early_m = 0;
  logic [31:0] desc_len = 0;
  logic [7:0] errm = 0;
  logic beat_valid = 0, beat_sop = 0, beat_eop = 0, buf_full = 0, stat_ready = 0;
  logic [3:0] beat_bytes = 0;
  logic [7:0] beat_err = 0;
  logic stat_valid;
  logic [255:0] stat_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wr_xfer_status_tracker uut (
    .clk(clk), .rst(rst), .desc_start(desc_start), .desc_len(desc_len),
    .desc_done_irq_mask(done_m), .desc_err_irq_mask(errm),
    .desc_early_irq_mask(early_m), .beat_valid(beat_valid),
    .beat_sop(beat_sop), .beat_eop(beat_eop), .beat_bytes(beat_bytes),
    .beat_err(beat_err), .buf_full(buf_full), .stat_valid(stat_valid),
    .stat_data(stat_data), .stat_ready(stat_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(input bit s, input bit e, input int b, input logic [7:0] er);
    beat_valid = 1; beat_sop = s; beat_eop = e; beat_bytes = b[3:0]; beat_err = er;
  endtask

  task automatic no_beat();
    beat_valid = 0; beat_sop = 0; beat_eop = 0; beat_bytes = 0; beat_err = 0;
  endtask

  task automatic start(input int len, input bit dm, input logic [7:0] em, input bit xm);
    @(negedge clk);
    desc_start = 1; desc_len = len; done_m = dm; errm = em; early_m = xm;
    @(negedge clk);
    desc_start = 0; desc_len = 32'hFFFF; done_m = ~dm; errm = ~em; early_m = ~xm;
  endtask

  task automatic run_case(input int len, input int n, input int seed);
    int cnt = 0;
    logic [7:0] er = 0;
    bit early = 0, fin = 0, bf = 0;
    logic [255:0] exp, held;
    logic [7:0] em = 8'hA5 ^ len[7:0];
    start(len, seed[0], em, n[0]);
    // R2: beat before start-of-packet is ignored, even with eop and errors
    beat(0, 1, 7, 8'h80);
    for (int i = 0; i < n && !fin; i++) begin
      int b = (i * 5 + seed * 3 + len) % 9;
      logic [7:0] e = ((i + seed) % 3 == 0) ? (8'd1 << ((i + len) % 7)) : 8'd0;
      @(negedge clk);
      beat(i == 0, i == n - 1, b, e);
      bf = ((i + seed) % 2) == 1;
      buf_full = bf;
      cnt += b; er |= e;
      if (i == n - 1) fin = 1;
      else if (cnt > len) begin fin = 1; early = 1; end
    end
    @(negedge clk);
    no_beat();
    buf_full = ~bf;
    exp = '0;
    exp[31:0] = cnt; exp[39:32] = er; exp[40] = early; exp[41] = seed[0];
    exp[49:42] = em; exp[50] = n[0]; exp[51] = bf;
    chk(stat_valid === 1'b1, "R8 valid after ending beat", stat_valid, 1);
    chk(stat_data[31:0] === exp[31:0], "R2 byte count", stat_data[31:0], exp[31:0]);
    chk(stat_data[39:32] === exp[39:32], "R3 sticky errors", stat_data[39:32], exp[39:32]);
    chk(stat_data[40] === early, "R4 R5 early flag", stat_data[40], early);
    chk(stat_data === exp, "R6 R7 full word", stat_data, exp);
    held = stat_data;
    desc_start = 1; desc_len = 0;
    @(negedge clk);
    desc_start = 0;
    @(negedge clk);
    chk(stat_valid === 1'b1 && stat_data === held, "R8 R9 held while not ready", stat_data, held);
    stat_ready = 1;
    @(negedge clk);
    stat_ready = 0;
    chk(stat_valid === 1'b0, "R8 handshake drops valid", stat_valid, 0);
    beat(1, 1, 3, 8'h01);
    @(negedge clk);
    no_beat();
    @(negedge clk);
    chk(stat_valid === 1'b0, "R9 R11 no transfer armed", stat_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stat_valid === 1'b0, "R1 reset valid", stat_valid, 0);
    rst = 0;
    // R11: beats with no descriptor
    beat(1, 1, 5, 8'h0F);
    @(negedge clk);
    no_beat();
    @(negedge clk);
    chk(stat_valid === 1'b0, "R1 R11 idle beats ignored", stat_valid, 0);
    // R5: count equal to length without eop continues
    start(8, 0, 8'h00, 0);
    beat(1, 0, 8, 8'h00);
    @(negedge clk);
    no_beat();
    @(negedge clk);
    chk(stat_valid === 1'b0, "R5 equal length keeps running", stat_valid, 0);
    beat(0, 1, 0, 8'h00);
    @(negedge clk);
    no_beat();
    chk(stat_valid === 1'b1 && stat_data[31:0] == 8 && !stat_data[40],
        "R5 eop ends at length", stat_data[40:0], 8);
    stat_ready = 1;
    @(negedge clk);
    stat_ready = 0;
    // R10: restart mid-transfer clears count and errors; same-cycle beat ignored
    start(40, 1, 8'h3C, 1);
    beat(1, 0, 5, 8'h10);
    @(negedge clk);
    desc_start = 1; desc_len = 40;
    @(negedge clk);
    desc_start = 0;
    beat(1, 1, 3, 8'h02);
    @(negedge clk);
    no_beat();
    chk(stat_valid === 1'b1 && stat_data[31:0] == 3 && stat_data[39:32] == 8'h02,
        "R10 restart clears", stat_data[39:0], {8'h02, 32'd3});
    stat_ready = 1;
    @(negedge clk);
    stat_ready = 0;
    for (int len = 0; len < 21; len++)
      for (int n = 1; n <= 6; n++)
        for (int s = 0; s < 3; s++)
          run_case(len, n, s);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule